// File: doc/BRIEF.md
# I2C bus timing compliance monitor

This block is a passive observer for a two-wire serial bus. It receives SCL and SDA samples that have already been synchronized to the system clock. It does not drive the bus. From the samples it finds START, repeated START and STOP conditions and the SCL edges of data bits. It counts system-clock cycles between the edge pairs that each fast-mode timing limit covers, and it compares each count with a threshold. The thresholds are given as nanosecond parameters and are rounded up to whole clock cycles.

Each timing parameter has its own sticky violation bit. Once set, a bit stays set until `clr_i` is pulsed. A separate counter records how many complete SCL periods (rising edge to rising edge) have been measured. After reset the monitor stays idle until it has seen both lines high for one bus-free window. Traffic during that time is ignored. The monitor does not measure rise and fall times, because its inputs are already digital. Minimum data hold is zero, so hold time needs no check.

Top module: `i2c_timing_mon`

## Requirements
- R1: After reset no event is evaluated and no flag can be set until SCL and SDA have both been sampled high for ARM consecutive cycles, where ARM equals the bus-free threshold in cycles.
- R2: Inside a transfer, a SCL low time (falling to rising edge) shorter than the low threshold sets `viol_o[1]`.
- R3: Inside a transfer, a SCL high time (rising to falling edge) shorter than the high threshold sets `viol_o[2]`.
- R4: The first SCL rising edge after a START or STOP is not measured. On each later rising edge of a transfer, `periods_o` increments by one. If the interval since the previous rising edge is shorter than the period threshold (1/400 kHz by default), `viol_o[0]` is set.
- R5: A START that follows a STOP by fewer cycles than the bus-free threshold sets `viol_o[3]`.
- R6: When the first SCL falling edge after a START or repeated START comes sooner than the START hold threshold, `viol_o[4]` is set.
- R7: A repeated START less than the repeated-START setup threshold after the last SCL rising edge sets `viol_o[5]`. A START while the bus is free is never checked this way.
- R8: A STOP less than the STOP setup threshold after the last SCL rising edge sets `viol_o[6]`.
- R9: When the last SDA change before a SCL rising edge inside a transfer is closer to that edge than the data setup threshold, `viol_o[7]` is set. A change in the same sample as the edge counts as zero setup.
- R10: Violation bits are sticky. A one-cycle pulse on `clr_i` zeroes them on the next edge. A violation found in the same cycle still sets its bit.
- R11: After reset every violation bit and `periods_o` read zero.
- R12: Each threshold in cycles is the nanosecond value divided by the clock period, rounded up. An interval of exactly that many cycles passes, and one cycle fewer fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| clr_i | input | 1 | Clears all violation bits |
| viol_o | output | 8 | Sticky flags: 0 period, 1 low, 2 high, 3 bus free, 4 START hold, 5 repeated-START setup, 6 STOP setup, 7 data setup |
| periods_o | output | CNT_W | Number of measured SCL periods, saturating |

## Verification
The bench builds the monitor with a 5 ns clock period and scaled-down thresholds: 60 ns low and bus free, 30 ns high and START/STOP timing, 100 ns period, and 6 ns data setup. Each frame therefore lasts only a few dozen cycles, and every limit can be hit exactly at its threshold and one cycle below it. The 6 ns setup limit rounds up to 2 cycles, which exercises the ceiling conversion. Each frame contains a repeated START, so every edge pair is seen in one pass. A further directed case starts a transfer from a free bus shortly after a SCL pulse, which checks that the repeated-START rule applies only to repeated STARTs.

// File: rtl/i2c_tmon_pkg.sv
package i2c_tmon_pkg;

    // violation bit positions
    localparam int VB_PERIOD = 0;
    localparam int VB_LOW    = 1;
    localparam int VB_HIGH   = 2;
    localparam int VB_BUF    = 3;
    localparam int VB_HDSTA  = 4;
    localparam int VB_SUSTA  = 5;
    localparam int VB_SUSTO  = 6;
    localparam int VB_SUDAT  = 7;
    localparam int NVIOL     = 8;

    // timer slots
    localparam int TM_SCL   = 0;   // since any SCL edge
    localparam int TM_SDA   = 1;   // since any SDA edge
    localparam int TM_RISE  = 2;   // since SCL rising edge
    localparam int TM_START = 3;   // since START
    localparam int TM_STOP  = 4;   // since STOP
    localparam int NTIMER   = 5;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    function automatic int ns2cyc(input int ns, input int per_ns);
        return (ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/i2c_tmon_cond.sv
module i2c_tmon_cond
    import i2c_tmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_edge_o,
    output logic start_o,
    output logic stop_o
);

    line_t prev_d, prev_q;

    always_comb begin
        prev_d     = prev_q;
        prev_d.scl = scl_i;
        prev_d.sda = sda_i;
        scl_rise_o = scl_i & ~prev_q.scl;
        scl_fall_o = ~scl_i & prev_q.scl;
        sda_edge_o = sda_i ^ prev_q.sda;
        start_o    = scl_i & prev_q.scl & prev_q.sda & ~sda_i;
        stop_o     = scl_i & prev_q.scl & ~prev_q.sda & sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // a START leaves SDA registered low on the following cycle
    assert_start_sda_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !prev_q.sda);

endmodule

// File: rtl/i2c_tmon_timer.sv
module i2c_tmon_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] SAT = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)          cnt_d = W'(1);
        else if (cnt_q != SAT)  cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= SAT;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_timer_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == W'(1)));

    assert_timer_saturates_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && cnt_q == SAT) |=> (cnt_q == SAT));

endmodule

// File: rtl/i2c_timing_mon.sv
module i2c_timing_mon
    import i2c_tmon_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_LOW_NS      = 1300,
    parameter int T_HIGH_NS     = 600,
    parameter int T_BUF_NS      = 1300,
    parameter int T_HDSTA_NS    = 600,
    parameter int T_SUSTA_NS    = 600,
    parameter int T_SUSTO_NS    = 600,
    parameter int T_SUDAT_NS    = 100,
    parameter int T_PERIOD_NS   = 2500,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             clr_i,
    output logic [7:0]       viol_o,
    output logic [CNT_W-1:0] periods_o
);

    localparam int CY_LOW    = ns2cyc(T_LOW_NS,    CLK_PERIOD_NS);
    localparam int CY_HIGH   = ns2cyc(T_HIGH_NS,   CLK_PERIOD_NS);
    localparam int CY_BUF    = ns2cyc(T_BUF_NS,    CLK_PERIOD_NS);
    localparam int CY_HDSTA  = ns2cyc(T_HDSTA_NS,  CLK_PERIOD_NS);
    localparam int CY_SUSTA  = ns2cyc(T_SUSTA_NS,  CLK_PERIOD_NS);
    localparam int CY_SUSTO  = ns2cyc(T_SUSTO_NS,  CLK_PERIOD_NS);
    localparam int CY_SUDAT  = ns2cyc(T_SUDAT_NS,  CLK_PERIOD_NS);
    localparam int CY_PERIOD = ns2cyc(T_PERIOD_NS, CLK_PERIOD_NS);
    localparam int CY_MAX    = max2(max2(max2(CY_LOW, CY_HIGH), max2(CY_BUF, CY_HDSTA)),
                                    max2(max2(CY_SUSTA, CY_SUSTO), max2(CY_SUDAT, CY_PERIOD)));
    localparam int TW        = $clog2(CY_MAX + 2);

    localparam logic [TW-1:0] C_LOW    = TW'(CY_LOW);
    localparam logic [TW-1:0] C_HIGH   = TW'(CY_HIGH);
    localparam logic [TW-1:0] C_BUF    = TW'(CY_BUF);
    localparam logic [TW-1:0] C_HDSTA  = TW'(CY_HDSTA);
    localparam logic [TW-1:0] C_SUSTA  = TW'(CY_SUSTA);
    localparam logic [TW-1:0] C_SUSTO  = TW'(CY_SUSTO);
    localparam logic [TW-1:0] C_SUDAT  = TW'(CY_SUDAT);
    localparam logic [TW-1:0] C_PERIOD = TW'(CY_PERIOD);
    localparam logic [TW-1:0] C_ARM    = TW'(CY_BUF - 1);

    typedef struct packed {
        logic              armed;
        logic [TW-1:0]     arm_cnt;
        logic              busy;
        logic              fall_seen;
        logic              rise_seen;
        logic              hold_pend;
        logic [NVIOL-1:0]  viol;
        logic [CNT_W-1:0]  periods;
    } st_t;

    st_t st_d, st_q;

    logic scl_rise, scl_fall, sda_edge, start_ev, stop_ev;
    logic [NTIMER-1:0] restart;
    logic [TW-1:0]     tc [NTIMER];
    logic [NVIOL-1:0]  newv;
    logic [TW-1:0]     setup_cyc;

    i2c_tmon_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_edge_o (sda_edge),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    always_comb begin
        restart           = '0;
        restart[TM_SCL]   = scl_rise | scl_fall;
        restart[TM_SDA]   = sda_edge;
        restart[TM_RISE]  = scl_rise;
        restart[TM_START] = start_ev & st_q.armed;
        restart[TM_STOP]  = stop_ev & st_q.armed;
    end

    for (genvar g = 0; g < NTIMER; g++) begin : g_tmr
        i2c_tmon_timer #(.W(TW)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart[g]),
            .cnt_o     (tc[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        newv      = '0;
        setup_cyc = sda_edge ? '0 : tc[TM_SDA];
        if (!st_q.armed) begin
            if (scl_i && sda_i) begin
                if (st_q.arm_cnt == C_ARM) st_d.armed = 1'b1;
                else                       st_d.arm_cnt = st_q.arm_cnt + TW'(1);
            end else begin
                st_d.arm_cnt = '0;
            end
        end else begin
            if (start_ev) begin
                if (st_q.busy) begin
                    if (tc[TM_SCL] < C_SUSTA) newv[VB_SUSTA] = 1'b1;
                end else begin
                    if (tc[TM_STOP] < C_BUF)  newv[VB_BUF] = 1'b1;
                end
                st_d.busy      = 1'b1;
                st_d.hold_pend = 1'b1;
                st_d.fall_seen = 1'b0;
                st_d.rise_seen = 1'b0;
            end else if (stop_ev) begin
                if (st_q.busy && tc[TM_SCL] < C_SUSTO) newv[VB_SUSTO] = 1'b1;
                st_d.busy      = 1'b0;
                st_d.hold_pend = 1'b0;
                st_d.fall_seen = 1'b0;
                st_d.rise_seen = 1'b0;
            end
            if (st_q.busy && scl_fall) begin
                if (tc[TM_SCL] < C_HIGH) newv[VB_HIGH] = 1'b1;
                if (st_q.hold_pend) begin
                    if (tc[TM_START] < C_HDSTA) newv[VB_HDSTA] = 1'b1;
                    st_d.hold_pend = 1'b0;
                end
                st_d.fall_seen = 1'b1;
            end
            if (st_q.busy && scl_rise) begin
                if (st_q.fall_seen && tc[TM_SCL] < C_LOW) newv[VB_LOW] = 1'b1;
                if (setup_cyc < C_SUDAT) newv[VB_SUDAT] = 1'b1;
                if (st_q.rise_seen) begin
                    if (tc[TM_RISE] < C_PERIOD) newv[VB_PERIOD] = 1'b1;
                    if (st_q.periods != '1) st_d.periods = st_q.periods + CNT_W'(1);
                end
                st_d.rise_seen = 1'b1;
            end
        end
        st_d.viol = (clr_i ? '0 : st_q.viol) | newv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol_o    = st_q.viol;
    assign periods_o = st_q.periods;

    assert_idle_no_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && st_q.viol == '0 && !clr_i) |=> (st_q.viol == '0));

    assert_armed_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.armed |=> st_q.armed);

    assert_period_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.periods == $past(st_q.periods)
               || st_q.periods == $past(st_q.periods) + CNT_W'(1)));

    assert_hold_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold_pend |-> st_q.busy);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q.viol & $past(st_q.viol)) == $past(st_q.viol)));

endmodule

// File: tb/i2c_timing_mon_bench.sv
module i2c_timing_mon_bench;

    localparam int ARM = 12;

    typedef struct packed {
        int lo; int hi; int su; int hds; int sus; int sto; int bf;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{14, 8, 4, 8, 8, 8, 14, 8'h00},
        '{11, 9, 4, 8, 8, 8, 14, 8'h02},
        '{12, 8, 4, 8, 8, 8, 14, 8'h00},
        '{15, 5, 4, 8, 8, 8, 14, 8'h04},
        '{14, 6, 4, 8, 8, 8, 14, 8'h00},
        '{13, 6, 4, 8, 8, 8, 14, 8'h01},
        '{14, 8, 1, 8, 8, 8, 14, 8'h80},
        '{14, 8, 2, 8, 8, 8, 14, 8'h00},
        '{14, 8, 4, 5, 8, 8, 14, 8'h10},
        '{14, 8, 4, 6, 8, 8, 14, 8'h00},
        '{14, 8, 4, 8, 5, 8, 14, 8'h20},
        '{14, 8, 4, 8, 6, 8, 14, 8'h00},
        '{14, 8, 4, 8, 8, 5, 14, 8'h40},
        '{14, 8, 4, 8, 8, 6, 14, 8'h00},
        '{14, 8, 4, 8, 8, 8, 11, 8'h08},
        '{14, 8, 4, 8, 8, 8, 12, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda = 1'b1;
    logic        clr = 1'b0;
    logic [7:0]  viol;
    logic [15:0] periods;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    i2c_timing_mon #(
        .CLK_PERIOD_NS (5),
        .T_LOW_NS      (60),
        .T_HIGH_NS     (30),
        .T_BUF_NS      (60),
        .T_HDSTA_NS    (30),
        .T_SUSTA_NS    (30),
        .T_SUSTO_NS    (30),
        .T_SUDAT_NS    (6),
        .T_PERIOD_NS   (100),
        .CNT_W         (16)
    ) u_i2c_timing_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda),
        .clr_i     (clr),
        .viol_o    (viol),
        .periods_o (periods)
    );

    function automatic string tag(input logic [7:0] e);
        case (e)
            8'h01:   return "R4";
            8'h02:   return "R2";
            8'h04:   return "R3";
            8'h08:   return "R5";
            8'h10:   return "R6";
            8'h20:   return "R7";
            8'h40:   return "R8";
            8'h80:   return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic d, input int n);
        scl = c;
        sda = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // START, two data bits, repeated START, one more clock, STOP
    task automatic frame(input vec_t v);
        drive(1, 1, v.bf - 3);
        drive(1, 0, v.hds);
        drive(0, 0, v.lo - v.su);
        drive(0, 1, v.su);
        drive(1, 1, v.hi);
        drive(0, 1, v.lo - v.su);
        drive(0, 0, v.su);
        drive(1, 0, v.hi);
        drive(0, 0, v.lo - v.su);
        drive(0, 1, v.su);
        drive(1, 1, v.sus);
        drive(1, 0, v.hds);
        drive(0, 0, v.lo);
        drive(1, 0, v.sto);
        drive(1, 1, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11", viol, 0);
        check("R11", periods, 0);

        // traffic before arming must be ignored (hold time 2 < 6)
        drive(1, 0, 2);
        drive(0, 0, 1);
        drive(1, 0, 1);
        drive(1, 1, 1);
        check("R1", viol, 0);
        drive(1, 1, ARM + 3);

        for (int i = 0; i < NV; i++) begin
            frame(VEC[i]);
            check(tag(VEC[i].exp), viol, VEC[i].exp);
            pulse_clr();
            check("R10", viol, 0);
        end
        check("R4", periods, 2 * NV);

        // stickiness: a violating frame, then a clean one without clear
        frame(VEC[8]);
        frame(VEC[0]);
        check("R10", viol, 8'h10);
        pulse_clr();

        // R7: START from a free bus right after an SCL pulse is not a repeated START
        drive(1, 1, 12);
        drive(0, 1, 3);
        drive(1, 1, 2);
        drive(1, 0, 8);
        drive(0, 0, 14);
        drive(1, 0, 8);
        drive(1, 1, 2);
        check("R7", viol, 0);
        check("R4", periods, 2 * NV + 4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule